// File: doc/BRIEF.md
# Outstanding End-of-Interrupt Tracker

This block follows a single edge-triggered interrupt line. Software and time-keeping code need to know whether an edge reached processors that have not yet acknowledged it. When the line's interrupt is delivered, the tracker records which processors accepted it. It then keeps an outstanding count and removes each processor from its record when that processor's end-of-interrupt arrives. While any acknowledgement is still missing, a new assertion of the line is reported as coalesced instead of being issued.

The delivery fabric that works out which processors accept an interrupt sits outside this block. It presents a delivery event together with the bitmap of accepting processors, or a failure indication when the delivery produced no valid result. A resynchronisation input reloads the record from the processors' own pending status. The fabric uses it whenever the tracked state must be rebuilt.

Top module: `eoi_tracker`

## Requirements
- R1: After reset, and after any later reset, the pending bitmap and the outstanding count are both zero.
- R2: In a cycle where the line is asserted, `coalesced_o` is 1 and `issue_o` is 0 if the count is non-zero. If the count is zero, `issue_o` is 1 and `coalesced_o` is 0. Both are 0 when the line is not asserted.
- R3: A delivery event arriving while the count is zero, without failure, loads the bitmap with the accepting-processor bitmap (bit i = processor i). From the next cycle the count equals the number of accepting processors.
- R4: A delivery event flagged as failed while the count is zero leaves bitmap and count at zero, as if no processor accepted.
- R5: A delivery event arriving while the count is non-zero is ignored. Acknowledgements in that cycle still apply.
- R6: An end-of-interrupt from processor i whose bitmap bit is set clears that bit and lowers the count by one. Several processors may acknowledge in the same cycle, and each one is removed.
- R7: An end-of-interrupt from a processor whose bitmap bit is clear changes neither the bitmap nor the count.
- R8: In a cycle where a delivery is accepted, all end-of-interrupt events are ignored. The bitmap becomes exactly the delivered bitmap.
- R9: A resynchronisation request loads the bitmap from the pending-status input and sets the count to its population. It takes priority over delivery and end-of-interrupt events in the same cycle.
- R10: The count always equals the number of set bits in the bitmap, and it never goes below zero or above the processor count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_req_i | input | 1 | New assertion of the tracked line |
| coalesced_o | output | 1 | Assertion is coalesced (acknowledgements outstanding) |
| issue_o | output | 1 | Assertion may be delivered (nothing outstanding) |
| dlv_valid_i | input | 1 | Delivery event |
| dlv_fail_i | input | 1 | Delivery produced no valid result |
| dlv_map_i | input | NUM_CPU (8) | Processors that accepted the delivery |
| ack_i | input | NUM_CPU (8) | Per-processor end-of-interrupt pulses |
| resync_i | input | 1 | Rebuild the record from pending status |
| resync_map_i | input | NUM_CPU (8) | Per-processor pending status for rebuild |
| pend_map_o | output | NUM_CPU (8) | Processors still owing an acknowledgement |
| pend_cnt_o | output | clog2(NUM_CPU+1) (4) | Outstanding acknowledgement count |

## Verification
The hardest situations to reach are the collisions. One is a delivery and acknowledgements landing in the same cycle while the count is zero. Another is a delivery arriving while acknowledgements are still owed and some are arriving at that moment. A resynchronisation overlapping both is a third. Directed steps place each collision on an exact cycle. A long random phase then mixes overlapping events with biased probabilities, and a behavioural per-processor model is compared against the bitmap, count and flags on every clock.

// File: rtl/eoi_tracker.sv
module eoi_tracker #(
  parameter int NUM_CPU = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             line_req_i,
  output logic                             coalesced_o,
  output logic                             issue_o,
  input  logic                             dlv_valid_i,
  input  logic                             dlv_fail_i,
  input  logic [NUM_CPU-1:0]               dlv_map_i,
  input  logic [NUM_CPU-1:0]               ack_i,
  input  logic                             resync_i,
  input  logic [NUM_CPU-1:0]               resync_map_i,
  output logic [NUM_CPU-1:0]               pend_map_o,
  output logic [$clog2(NUM_CPU+1)-1:0]     pend_cnt_o
);
  localparam int CNT_W = $clog2(NUM_CPU + 1);

  function automatic logic [CNT_W-1:0] ones(input logic [NUM_CPU-1:0] v);
    logic [CNT_W-1:0] s;
    s = '0;
    for (int i = 0; i < NUM_CPU; i++) s = s + CNT_W'(v[i]);
    return s;
  endfunction

  logic [NUM_CPU-1:0] map_q, map_d, hit;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               idle;

  assign idle        = (cnt_q == '0);
  assign coalesced_o = line_req_i & ~idle;
  assign issue_o     = line_req_i & idle;
  assign hit         = ack_i & map_q;

  always_comb begin
    map_d = map_q;
    cnt_d = cnt_q;
    if (resync_i) begin
      map_d = resync_map_i;
      cnt_d = ones(resync_map_i);
    end else if (dlv_valid_i && idle) begin
      if (dlv_fail_i) begin
        map_d = '0;
        cnt_d = '0;
      end else begin
        map_d = dlv_map_i;
        cnt_d = ones(dlv_map_i);
      end
    end else if (|hit) begin
      map_d = map_q & ~hit;
      cnt_d = cnt_q - ones(hit);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q <= '0;
      cnt_q <= '0;
    end else begin
      map_q <= map_d;
      cnt_q <= cnt_d;
    end
  end

  assign pend_map_o = map_q;
  assign pend_cnt_o = cnt_q;
endmodule

// File: rtl/eoi_tracker_chk.sv
module eoi_tracker_chk #(
  parameter int NUM_CPU = 8,
  parameter int CNT_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req,
  input logic               coal,
  input logic               issue,
  input logic               dv,
  input logic               dfail,
  input logic [NUM_CPU-1:0] dmap,
  input logic [NUM_CPU-1:0] ack,
  input logic               rs,
  input logic [NUM_CPU-1:0] rsmap,
  input logic [NUM_CPU-1:0] map,
  input logic [CNT_W-1:0]   cnt
);
  assert_cnt_popcount_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == CNT_W'($countones(map)));

  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (coal ^ issue));

  assert_coal_needs_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    coal |-> (map != '0));

  assert_accept_loads_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rs && dv && !dfail && cnt == '0) |=> (map == $past(dmap)));

  assert_busy_delivery_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rs && dv && cnt != '0 && ack == '0) |=> $stable(map));

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rs && !(dv && cnt == '0) && ack != '0) |=> ((map & $past(ack)) == '0));

  assert_resync_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rs |=> (map == $past(rsmap)));
endmodule

bind eoi_tracker eoi_tracker_chk #(.NUM_CPU(NUM_CPU), .CNT_W(CNT_W)) chk_i (
  .clk(clk_i), .rst_n(rst_ni), .req(line_req_i), .coal(coalesced_o), .issue(issue_o),
  .dv(dlv_valid_i), .dfail(dlv_fail_i), .dmap(dlv_map_i), .ack(ack_i),
  .rs(resync_i), .rsmap(resync_map_i), .map(pend_map_o), .cnt(pend_cnt_o)
);

// File: tb/eoi_tracker_tb_top.sv
`timescale 1ns/1ps
module eoi_tracker_tb_top;
  localparam int N  = 8;
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, dv = 1'b0, dfail = 1'b0, rs = 1'b0;
  logic [N-1:0] dmap = '0, ack = '0, rsmap = '0;
  logic coal, issue;
  logic [N-1:0] map;
  logic [CW-1:0] cnt;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int pend[N];
  int pcount = 0;

  always #2 clk = ~clk;

  eoi_tracker #(.NUM_CPU(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .line_req_i(req), .coalesced_o(coal), .issue_o(issue),
    .dlv_valid_i(dv), .dlv_fail_i(dfail), .dlv_map_i(dmap), .ack_i(ack),
    .resync_i(rs), .resync_map_i(rsmap), .pend_map_o(map), .pend_cnt_o(cnt)
  );

  function automatic logic [N-1:0] model_map();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (pend[i] != 0);
    return v;
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) pend[i] = 0;
    pcount = 0;
  endtask

  task automatic model_load(input logic [N-1:0] v);
    pcount = 0;
    for (int i = 0; i < N; i++) begin
      pend[i] = v[i];
      pcount += v[i];
    end
  endtask

  task automatic step(input string tag, input logic r, input logic d, input logic f,
                      input logic [N-1:0] dm, input logic [N-1:0] a,
                      input logic s, input logic [N-1:0] sm);
    @(negedge clk);
    req = r; dv = d; dfail = f; dmap = dm; ack = a; rs = s; rsmap = sm;
    #1;
    check("R2", int'(coal), int'(r && pcount > 0), "coalesced");
    check("R2", int'(issue), int'(r && pcount == 0), "issue");
    @(posedge clk);
    if (s) model_load(sm);
    else if (d && pcount == 0) begin
      if (f) model_clear(); else model_load(dm);
    end else begin
      for (int i = 0; i < N; i++)
        if (a[i] && pend[i] != 0) begin
          pend[i] = 0;
          pcount--;
        end
    end
    #1;
    check(tag, int'(map), int'(model_map()), "pend_map");
    check(tag, int'(cnt), pcount, "pend_cnt");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req = 0; dv = 0; dfail = 0; dmap = '0; ack = '0; rs = 0; rsmap = '0;
    model_clear();
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    check("R1", int'(map), 0, "pend_map after reset");
    check("R1", int'(cnt), 0, "pend_cnt after reset");
  endtask

  initial begin
    do_reset();
    step("R2", 1, 0, 0, '0, '0, 0, '0);
    step("R3", 0, 1, 0, 8'b1011_0010, '0, 0, '0);
    step("R2", 1, 0, 0, '0, '0, 0, '0);
    step("R5", 0, 1, 0, 8'hFF, '0, 0, '0);
    step("R5", 0, 1, 0, 8'hFF, 8'b0000_0010, 0, '0);
    step("R7", 0, 0, 0, '0, 8'b0000_0001, 0, '0);
    step("R6", 1, 0, 0, '0, 8'b0011_0000, 0, '0);
    step("R6", 0, 0, 0, '0, 8'b1000_0000, 0, '0);
    step("R2", 1, 0, 0, '0, '0, 0, '0);
    step("R4", 0, 1, 1, 8'h0F, '0, 0, '0);
    step("R8", 0, 1, 0, 8'h0C, 8'h04, 0, '0);
    step("R9", 0, 1, 0, 8'h33, 8'h0C, 1, 8'hA5);
    step("R6", 0, 0, 0, '0, 8'hFF, 0, '0);
    step("R10", 0, 1, 0, 8'hFF, '0, 0, '0);
    step("R10", 0, 0, 0, '0, 8'hFF, 0, '0);
    step("R3", 0, 1, 0, 8'h81, '0, 0, '0);
    do_reset();
    for (int k = 0; k < 400; k++) begin
      logic [3:0] sel;
      sel = 4'($urandom);
      step("R10", 1'($urandom), sel[1:0] == 0, sel[3:2] == 0, N'($urandom),
           N'($urandom) & N'($urandom), sel == 4'hF, N'($urandom));
    end
    do_reset();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d cycles", cycles, 100000);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end
endmodule